// File: doc/BRIEF.md
# Heartbeat-Gated PWM Lane Selector

This block picks which of two servo-style PWM streams reaches the motor controller. The radio receiver lane is the default. The on-board controller lane is used only while the controller keeps toggling a heartbeat line. A select line that is held high or held low carries no edges, so the radio lane takes the output back. The block stands in for an analogue RC filter on a select pin. Its place is taken by a counter that restarts on every heartbeat edge.

The heartbeat passes through a synchroniser. Both its rising and its falling edges count. The controller lane is granted only after a run of `ARM_EDGES` edges in which each gap is shorter than `TIMEOUT_CYC` clock cycles. A glitching heartbeat therefore cannot make the output chatter between lanes.

A move onto the controller lane waits until both PWM inputs are low, so no pulse is clipped or merged on the way in. When the heartbeat times out, the block returns to the radio lane at once, even if this cuts a controller pulse short. Each such fallback sets a sticky event flag, and writing one to the clear input clears it. The default timeout is 25 ms at `CLK_HZ` (`CLK_HZ/40` cycles), which stays inside a 30 ms fallback budget.

Top module: `pwm_lane_sel`

## Requirements
- R1: After reset is asserted, the radio lane is selected, `lane_is_ctrl_o` is 0 and `fallback_evt_o` is 0.
- R2: While the radio lane is selected, `pwm_o` equals `radio_pwm_i` in the same cycle.
- R3: While the controller lane is selected (`lane_is_ctrl_o` = 1), `pwm_o` equals `ctrl_pwm_i` in the same cycle.
- R4: Rising and falling heartbeat edges both count. The controller lane becomes eligible once `ARM_EDGES` consecutive edges have arrived, each less than `TIMEOUT_CYC` cycles after the previous one. Fewer edges leave the radio lane selected.
- R5: When the gap between heartbeat edges reaches `TIMEOUT_CYC` cycles, the run of edges restarts. A heartbeat slower than the timeout never selects the controller lane.
- R6: In the controller lane, if `TIMEOUT_CYC` cycles pass with no heartbeat edge, the radio lane is selected on the next cycle, whatever the PWM levels are. A heartbeat stuck high or stuck low therefore falls back.
- R7: A switch from the radio lane to the controller lane happens only in a cycle where `radio_pwm_i` and `ctrl_pwm_i` are both 0.
- R8: Every fallback from the controller lane to the radio lane sets `fallback_evt_o`. The flag stays set until `evt_clr_i` is 1 in a cycle with no new fallback; if both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hb_i | input | 1 | Heartbeat from the controller, asynchronous |
| radio_pwm_i | input | 1 | PWM stream from the radio receiver |
| ctrl_pwm_i | input | 1 | PWM stream from the on-board controller |
| evt_clr_i | input | 1 | Write-one clear of the fallback flag |
| pwm_o | output | 1 | PWM to the motor controller |
| lane_is_ctrl_o | output | 1 | 1 while the controller lane is selected |
| fallback_evt_o | output | 1 | Sticky flag: a fallback to the radio lane has occurred |

## Verification
The bench goes after how the heartbeat run is counted:
- One edge short of `ARM_EDGES` must leave the radio lane selected. A design that counts only one edge polarity, or is off by one, arms too late or too early.
- Gaps just inside and just past the timeout must split cleanly between arming and never arming. A design that does not restart the run on a long gap would arm on a slow heartbeat.

Fallback is checked from both sides of the timeout, with the heartbeat stuck high, and with a controller pulse still high at expiry. A design that waited for low PWM before falling back would keep driving that pulse.

Handover onto the controller lane is tried while the radio pulse is high. An ungated design would switch in mid-pulse.

The event flag is checked for stickiness and for write-one clearing.

// File: rtl/pwm_sel_pkg.sv
package pwm_sel_pkg;
  typedef enum logic {
    LANE_RADIO = 1'b0,
    LANE_CTRL  = 1'b1
  } lane_e;
endpackage

// File: rtl/hb_edge_det.sv
module hb_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic edge_o
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-2:0], hb_i};
  end

  // either polarity counts
  assign edge_o = sr_q[SR_W-1] ^ sr_q[SR_W-2];
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int TIMEOUT_CYC = 2500000,
  parameter int ARM_EDGES   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic hb_ok_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int SW = $clog2(ARM_EDGES + 1);
  localparam logic [CW-1:0] TO_V  = CW'(TIMEOUT_CYC);
  localparam logic [SW-1:0] ARM_V = SW'(ARM_EDGES);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] streak_q;
  logic          expired;

  assign expired = (cnt_q == TO_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= TO_V;
      streak_q <= '0;
    end else if (edge_i) begin
      cnt_q    <= '0;
      if (expired)                streak_q <= SW'(1);
      else if (streak_q != ARM_V) streak_q <= streak_q + SW'(1);
    end else if (!expired) begin
      cnt_q <= cnt_q + CW'(1);
    end else begin
      streak_q <= '0;
    end
  end

  assign hb_ok_o = (streak_q == ARM_V) && !expired;

  // R4
  arm_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_ok_o) |-> $past(edge_i));

  // R6
  drop_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hb_ok_o) |-> expired);
endmodule

// File: rtl/lane_switch.sv
module lane_switch
  import pwm_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_ok_i,
  input  logic radio_pwm_i,
  input  logic ctrl_pwm_i,
  input  logic evt_clr_i,
  output logic pwm_o,
  output logic lane_is_ctrl_o,
  output logic fallback_evt_o
);
  lane_e lane_q, lane_d;
  logic  fall_back, evt_q;

  always_comb begin
    lane_d    = lane_q;
    fall_back = 1'b0;
    if (lane_q == LANE_CTRL) begin
      if (!hb_ok_i) begin
        lane_d    = LANE_RADIO;
        fall_back = 1'b1;
      end
    end else if (hb_ok_i && !radio_pwm_i && !ctrl_pwm_i) begin
      lane_d = LANE_CTRL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= LANE_RADIO;
      evt_q  <= 1'b0;
    end else begin
      lane_q <= lane_d;
      evt_q  <= fall_back | (evt_q & ~evt_clr_i);
    end
  end

  assign pwm_o          = (lane_q == LANE_CTRL) ? ctrl_pwm_i : radio_pwm_i;
  assign lane_is_ctrl_o = (lane_q == LANE_CTRL);
  assign fallback_evt_o = evt_q;

  // R7
  quiet_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_is_ctrl_o) |-> $past(!radio_pwm_i && !ctrl_pwm_i && hb_ok_i));

  // R6
  fallback_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lane_is_ctrl_o) |-> $past(!hb_ok_i));

  // R8
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_evt_o && !evt_clr_i |=> fallback_evt_o);

  // R8
  evt_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fallback_evt_o) |-> $past(lane_is_ctrl_o) && !lane_is_ctrl_o);
endmodule

// File: rtl/pwm_lane_sel.sv
module pwm_lane_sel #(
  parameter int CLK_HZ      = 100000000,
  parameter int TIMEOUT_CYC = CLK_HZ / 40,
  parameter int ARM_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  input  logic radio_pwm_i,
  input  logic ctrl_pwm_i,
  input  logic evt_clr_i,
  output logic pwm_o,
  output logic lane_is_ctrl_o,
  output logic fallback_evt_o
);
  logic hb_edge, hb_ok;

  hb_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hb_i   (hb_i),
    .edge_o (hb_edge)
  );

  hb_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC), .ARM_EDGES(ARM_EDGES)) wdog_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (hb_edge),
    .hb_ok_o (hb_ok)
  );

  lane_switch sw_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hb_ok_i        (hb_ok),
    .radio_pwm_i    (radio_pwm_i),
    .ctrl_pwm_i     (ctrl_pwm_i),
    .evt_clr_i      (evt_clr_i),
    .pwm_o          (pwm_o),
    .lane_is_ctrl_o (lane_is_ctrl_o),
    .fallback_evt_o (fallback_evt_o)
  );

  // R2
  radio_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_is_ctrl_o |-> pwm_o == radio_pwm_i);
endmodule

// File: tb/pwm_lane_sel_tb.sv
module pwm_lane_sel_tb_top;
  localparam int TO  = 200;
  localparam int ARM = 4;
  localparam int NV  = 6;

  // {edges, gap cycles, expect ctrl lane}
  typedef struct packed { int edges; int gap; logic exp_ctrl; } vec_t;
  localparam vec_t VECS [NV] = '{
    '{3,   50, 1'b0},   // R4 one short
    '{4,   50, 1'b1},   // R4 exact
    '{4,  199, 1'b1},   // R5 just inside
    '{8,  205, 1'b0},   // R5 just past
    '{10, 400, 1'b0},   // R5 slow
    '{12,  10, 1'b1}    // R4 fast
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hb = 1'b0, radio = 1'b0, ctrl = 1'b0, clr = 1'b0;
  logic pwm, lane_ctrl, evt;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_lane_sel #(.TIMEOUT_CYC(TO), .ARM_EDGES(ARM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hb_i(hb), .radio_pwm_i(radio),
    .ctrl_pwm_i(ctrl), .evt_clr_i(clr), .pwm_o(pwm),
    .lane_is_ctrl_o(lane_ctrl), .fallback_evt_o(evt)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggles(int n, int gap);
    for (int i = 0; i < n; i++) begin
      wait_cyc(gap);
      hb = ~hb;
    end
  endtask

  task automatic go_ctrl();
    toggles(ARM + 2, 40);
    wait_cyc(5);
  endtask

  initial begin
    wait_cyc(3);
    // R1 reset state
    check("R1 lane", lane_ctrl, 1'b0);
    check("R1 evt", evt, 1'b0);
    rst_n = 1'b1;
    wait_cyc(2);
    radio = 1'b1; #1;
    check("R2 radio high", pwm, 1'b1);
    radio = 1'b0; #1;
    check("R2 radio low", pwm, 1'b0);

    for (int v = 0; v < NV; v++) begin
      wait_cyc(TO + 50);
      toggles(VECS[v].edges, VECS[v].gap);
      wait_cyc(10);
      check($sformatf("R4/R5 vec%0d", v), lane_ctrl, VECS[v].exp_ctrl);
    end

    // R6 fallback timing from last edge
    wait_cyc(TO + 50);
    clr = 1'b1; wait_cyc(1); clr = 1'b0;
    go_ctrl();
    check("R6 armed", lane_ctrl, 1'b1);
    ctrl = 1'b1; #1;
    check("R3 ctrl high", pwm, 1'b1);
    ctrl = 1'b0; #1;
    check("R3 ctrl low", pwm, 1'b0);
    hb = ~hb;
    wait_cyc(190);
    check("R6 before timeout", lane_ctrl, 1'b1);
    check("R8 no evt yet", evt, 1'b0);
    wait_cyc(20);
    check("R6 after timeout", lane_ctrl, 1'b0);
    check("R8 evt set", evt, 1'b1);
    wait_cyc(30);
    check("R8 sticky", evt, 1'b1);
    clr = 1'b1; wait_cyc(1); clr = 1'b0; wait_cyc(1);
    check("R8 cleared", evt, 1'b0);

    // R6 stuck high, controller pulse cut at expiry
    wait_cyc(TO + 50);
    if (hb) hb = 1'b0;
    go_ctrl();
    check("R6 armed2", lane_ctrl, 1'b1);
    hb = 1'b1;
    ctrl = 1'b1;
    wait_cyc(TO + 20);
    check("R6 stuck high lane", lane_ctrl, 1'b0);
    check("R6 pulse cut", pwm, 1'b0);
    ctrl = 1'b0;

    // R7 handover waits for radio low
    wait_cyc(TO + 50);
    radio = 1'b1;
    toggles(ARM + 2, 40);
    wait_cyc(3);
    check("R7 held on radio", lane_ctrl, 1'b0);
    check("R7 pwm radio", pwm, 1'b1);
    radio = 1'b0;
    toggles(1, 20);
    wait_cyc(5);
    check("R7 switched", lane_ctrl, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hang expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule